// File: doc/BRIEF.md
# Nested-Task Return Link Checker

When an interrupt return finds the nested-task flag set, control goes back to the task whose selector sits in the current task-state segment. This block reads that back-link selector and fetches the global descriptor it names. It then decides whether the descriptor is a legal target for the return. It drives a simple read port into memory. It ends every request with a one-cycle completion pulse that carries one of two results: the selector and both descriptor words for a task-switch unit, or a fault class and an error code.

A request is one `start_i` pulse. The pulse comes with the base of the current task-state segment, the global table base and the table limit, and the state of the virtual-8086 flag. The block does not perform the task switch.

Top module: `ntl_link_check`

## Requirements
- R1: The first memory read of a request is at `tss_base_i`, and the low 16 bits of the returned word are taken as the back-link selector.
- R2: If selector bit 2 (the local-table indicator) is 1, the result is fault class 1 (invalid TSS) with error code = selector with bits 1:0 cleared, and no descriptor is read.
- R3: If selector bits 15:3 times 8, plus 7, exceed `gdt_limit_i`, the result is fault class 1 with the masked selector, and no descriptor is read.
- R4: The descriptor high word must have bit 12 (S) = 0 and bits 11:8 equal to 4'h3 (busy 16-bit TSS) or 4'hB (busy 32-bit TSS). Otherwise the result is fault class 1 with the masked selector.
- R5: If the descriptor passes R4 but high-word bit 15 (present) is 0, the result is fault class 2 (not present) with the masked selector.
- R6: Checks are applied in the order local-table, limit, type, present. Only the first failure is reported.
- R7: On success, `ok_o` = 1 and fault class = 0. `link_sel_o` carries the full selector, including its RPL bits, and `desc_lo_o`/`desc_hi_o` carry the two descriptor words.
- R8: If `v86_i` is 1 at start, the result is fault class 3 (internal error) with error code 0, and no memory read is issued.
- R9: `done_o` is high for exactly one cycle per request. The result outputs keep their values until the next start.
- R10: The descriptor is read as two words, first at `gdt_base_i` + index*8 and then at that address + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request pulse, accepted when idle |
| v86_i | input | 1 | Virtual-8086 flag at request time |
| tss_base_i | input | AW | Base address of the current task-state segment |
| gdt_base_i | input | AW | Base address of the global descriptor table |
| gdt_limit_i | input | LW | Global table limit in bytes |
| mem_req_o | output | 1 | Read request, held until acknowledged |
| mem_addr_o | output | AW | Read address, stable while requesting |
| mem_ack_i | input | 1 | Read acknowledge with data |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Link is valid |
| fault_o | output | 2 | 0 none, 1 invalid TSS, 2 not present, 3 internal |
| err_code_o | output | 16 | Selector with bits 1:0 cleared, or 0 |
| link_sel_o | output | 16 | Back-link selector as read |
| desc_lo_o | output | 32 | Descriptor low word |
| desc_hi_o | output | 32 | Descriptor high word |

## Verification
The properties rely on three input rules:
- `mem_ack_i` is raised only while `mem_req_o` is high.
- `start_i` is a single-cycle pulse given only while the block is idle.
- Data is valid in the acknowledge cycle.

The bench keeps to these rules with its own memory model. It acknowledges exactly one cycle after it sees a fresh request. It starts each request only after the previous completion pulse has been observed.

// File: rtl/ntl_pkg.sv
package ntl_pkg;
    localparam int SEL_W = 16;
    localparam int DW    = 32;

    // descriptor high-word fields
    localparam int HI_PRESENT = 15;
    localparam int HI_SYSBIT  = 12;
    localparam int HI_TYPE_LO = 8;

    localparam logic [3:0] TSS_BUSY16 = 4'h3;
    localparam logic [3:0] TSS_BUSY32 = 4'hB;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_TS   = 2'd1,
        FLT_NP   = 2'd2,
        FLT_INT  = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LINK = 3'd1,
        ST_SEL  = 3'd2,
        ST_DLO  = 3'd3,
        ST_DHI  = 3'd4,
        ST_EVAL = 3'd5
    } state_e;
endpackage

// File: rtl/ntl_limit_chk.sv
module ntl_limit_chk #(
    parameter int LW = 16
) (
    input  logic [12:0]   index_i,
    input  logic [LW-1:0] limit_i,
    output logic          over_o
);
    localparam int CW = (LW > 16) ? LW + 1 : 17;
    logic [CW-1:0] last_byte;
    logic [CW-1:0] lim_ext;

    always_comb begin
        last_byte = CW'({index_i, 3'b111});
        lim_ext   = CW'(limit_i);
        over_o    = last_byte > lim_ext;
    end
endmodule

// File: rtl/ntl_desc_class.sv
module ntl_desc_class
    import ntl_pkg::*;
(
    input  logic [7:0] hi_attr_i,  // descriptor high word bits 15:8
    output logic       busy_tss_o,
    output logic       present_o
);
    localparam int P_OFF = HI_PRESENT - HI_TYPE_LO;
    localparam int S_OFF = HI_SYSBIT - HI_TYPE_LO;

    logic [3:0] seg_type;

    always_comb begin
        seg_type   = hi_attr_i[3:0];
        busy_tss_o = !hi_attr_i[S_OFF] &&
                     ((seg_type == TSS_BUSY16) || (seg_type == TSS_BUSY32));
        present_o  = hi_attr_i[P_OFF];
    end
endmodule

// File: rtl/ntl_addr_gen.sv
module ntl_addr_gen #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] table_base_i,
    input  logic [12:0]   index_i,
    input  logic          upper_i,
    output logic [AW-1:0] addr_o
);
    localparam int OW = (AW > 16) ? AW : 16;
    logic [OW-1:0] offset;

    always_comb begin
        offset = OW'({index_i, upper_i, 2'b00});
        addr_o = table_base_i + AW'(offset);
    end
endmodule

// File: rtl/ntl_link_check.sv
module ntl_link_check
    import ntl_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             v86_i,
    input  logic [AW-1:0]    tss_base_i,
    input  logic [AW-1:0]    gdt_base_i,
    input  logic [LW-1:0]    gdt_limit_i,
    output logic             mem_req_o,
    output logic [AW-1:0]    mem_addr_o,
    input  logic             mem_ack_i,
    input  logic [DW-1:0]    mem_rdata_i,
    output logic             done_o,
    output logic             ok_o,
    output logic [1:0]       fault_o,
    output logic [SEL_W-1:0] err_code_o,
    output logic [SEL_W-1:0] link_sel_o,
    output logic [DW-1:0]    desc_lo_o,
    output logic [DW-1:0]    desc_hi_o
);
    localparam int TI_BIT = 2;

    typedef struct packed {
        state_e           st;
        logic [AW-1:0]    tss;
        logic [AW-1:0]    gdt;
        logic [LW-1:0]    lim;
        logic [SEL_W-1:0] sel;
        logic [DW-1:0]    lo;
        logic [DW-1:0]    hi;
        logic             done;
        logic             ok;
        fault_e           flt;
        logic [SEL_W-1:0] err;
    } regs_t;

    regs_t r_d, r_q;

    logic          over_limit;
    logic          busy_tss;
    logic          present;
    logic [AW-1:0] desc_addr;

    ntl_limit_chk #(.LW(LW)) u_limit (
        .index_i (r_q.sel[SEL_W-1:3]),
        .limit_i (r_q.lim),
        .over_o  (over_limit)
    );

    ntl_desc_class u_class (
        .hi_attr_i  (r_q.hi[HI_PRESENT:HI_TYPE_LO]),
        .busy_tss_o (busy_tss),
        .present_o  (present)
    );

    ntl_addr_gen #(.AW(AW)) u_addr (
        .table_base_i (r_q.gdt),
        .index_i      (r_q.sel[SEL_W-1:3]),
        .upper_i      (r_q.st == ST_DHI),
        .addr_o       (desc_addr)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.tss = tss_base_i;
                    r_d.gdt = gdt_base_i;
                    r_d.lim = gdt_limit_i;
                    r_d.ok  = 1'b0;
                    r_d.flt = FLT_NONE;
                    r_d.err = '0;
                    if (v86_i) begin
                        r_d.done = 1'b1;
                        r_d.flt  = FLT_INT;
                    end else begin
                        r_d.st = ST_LINK;
                    end
                end
            end
            ST_LINK: begin
                if (mem_ack_i) begin
                    r_d.sel = mem_rdata_i[SEL_W-1:0];
                    r_d.st  = ST_SEL;
                end
            end
            ST_SEL: begin
                if (r_q.sel[TI_BIT] || over_limit) begin
                    r_d.done = 1'b1;
                    r_d.flt  = FLT_TS;
                    r_d.err  = {r_q.sel[SEL_W-1:2], 2'b00};
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.st = ST_DLO;
                end
            end
            ST_DLO: begin
                if (mem_ack_i) begin
                    r_d.lo = mem_rdata_i;
                    r_d.st = ST_DHI;
                end
            end
            ST_DHI: begin
                if (mem_ack_i) begin
                    r_d.hi = mem_rdata_i;
                    r_d.st = ST_EVAL;
                end
            end
            ST_EVAL: begin
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
                if (!busy_tss) begin
                    r_d.flt = FLT_TS;
                    r_d.err = {r_q.sel[SEL_W-1:2], 2'b00};
                end else if (!present) begin
                    r_d.flt = FLT_NP;
                    r_d.err = {r_q.sel[SEL_W-1:2], 2'b00};
                end else begin
                    r_d.ok = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_IDLE;
            r_q.flt <= FLT_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mem_req_o  = (r_q.st == ST_LINK) || (r_q.st == ST_DLO) || (r_q.st == ST_DHI);
        mem_addr_o = (r_q.st == ST_LINK) ? r_q.tss : desc_addr;
        done_o     = r_q.done;
        ok_o       = r_q.ok;
        fault_o    = r_q.flt;
        err_code_o = r_q.err;
        link_sel_o = r_q.sel;
        desc_lo_o  = r_q.lo;
        desc_hi_o  = r_q.hi;
    end
endmodule

// File: rtl/ntl_link_check_sva.sv
module ntl_link_check_sva #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req_o,
    input logic          mem_ack_i,
    input logic [AW-1:0] mem_addr_o,
    input logic          done_o,
    input logic          ok_o,
    input logic [1:0]    fault_o,
    input logic [15:0]   err_code_o,
    input logic [15:0]   link_sel_o,
    input logic [31:0]   desc_hi_o
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)); // R1

    AST_ERR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && fault_o != 2'd0 |-> err_code_o[1:0] == 2'b00); // R2

    AST_OK_BUSY_TSS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && ok_o |-> !desc_hi_o[12] &&
            (desc_hi_o[11:8] == 4'h3 || desc_hi_o[11:8] == 4'hB)); // R4

    AST_NP_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && fault_o == 2'd2 |-> !desc_hi_o[15]); // R5

    AST_OK_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && ok_o |-> !link_sel_o[2] && fault_o == 2'd0 && desc_hi_o[15]); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
endmodule

bind ntl_link_check ntl_link_check_sva #(.AW(AW)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req_o  (mem_req_o),
    .mem_ack_i  (mem_ack_i),
    .mem_addr_o (mem_addr_o),
    .done_o     (done_o),
    .ok_o       (ok_o),
    .fault_o    (fault_o),
    .err_code_o (err_code_o),
    .link_sel_o (link_sel_o),
    .desc_hi_o  (desc_hi_o)
);

// File: tb/ntl_link_check_bench.sv
module ntl_link_check_bench;
    localparam logic [15:0] TSS_BASE = 16'h0040;
    localparam logic [15:0] GDT_BASE = 16'h0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        v86_i = 1'b0;
    logic [15:0] tss_base_i = TSS_BASE;
    logic [15:0] gdt_base_i = GDT_BASE;
    logic [15:0] gdt_limit_i = 16'h00FF;
    logic        mem_req_o;
    logic [15:0] mem_addr_o;
    logic        mem_ack_i;
    logic [31:0] mem_rdata_i;
    logic        done_o, ok_o;
    logic [1:0]  fault_o;
    logic [15:0] err_code_o, link_sel_o;
    logic [31:0] desc_lo_o, desc_hi_o;

    logic [31:0] mem [0:255];
    logic [15:0] req_log [0:1023];
    int          n_req;
    int          n_chk;
    int          n_fail;

    always #10 clk = ~clk;

    ntl_link_check u_ntl_link_check (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .v86_i(v86_i),
        .tss_base_i(tss_base_i), .gdt_base_i(gdt_base_i), .gdt_limit_i(gdt_limit_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
        .mem_rdata_i(mem_rdata_i), .done_o(done_o), .ok_o(ok_o), .fault_o(fault_o),
        .err_code_o(err_code_o), .link_sel_o(link_sel_o),
        .desc_lo_o(desc_lo_o), .desc_hi_o(desc_hi_o)
    );

    // memory model: acknowledges one cycle after a fresh request
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack_i   <= 1'b0;
            mem_rdata_i <= '0;
            n_req       <= 0;
        end else if (mem_req_o && !mem_ack_i) begin
            mem_ack_i   <= 1'b1;
            mem_rdata_i <= mem[mem_addr_o[9:2]];
            req_log[n_req[9:0]] <= mem_addr_o;
            n_req       <= n_req + 1;
        end else begin
            mem_ack_i <= 1'b0;
        end
    end

    task automatic chk(input bit cond, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [15:0] sel, input logic [31:0] lo,
                       input logic [31:0] hi, input logic [15:0] lim, input logic v86);
        int base, waited;
        logic [1:0]  e_flt;
        logic [15:0] e_err;
        int          e_reqs;
        logic [3:0]  ty;
        mem[16] = {16'hA5A5, sel};
        mem[64 + 2*int'(sel[15:3])]     = lo;
        mem[64 + 2*int'(sel[15:3]) + 1] = hi;
        base = n_req;
        @(negedge clk);
        start_i = 1'b1; v86_i = v86; gdt_limit_i = lim;
        @(negedge clk);
        start_i = 1'b0;
        waited = 0;
        while (!done_o && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        chk(done_o, "R9 done seen", 32'(done_o), 32'd1);
        // expected outcome from the requirements
        ty = hi[11:8];
        e_err = {sel[15:2], 2'b00};
        if (v86) begin
            e_flt = 2'd3; e_err = 16'h0; e_reqs = 0;              // R8
        end else if (sel[2]) begin
            e_flt = 2'd1; e_reqs = 1;                             // R2
        end else if ((32'(sel[15:3]) * 8 + 7) > 32'(lim)) begin
            e_flt = 2'd1; e_reqs = 1;                             // R3
        end else if (hi[12] || (ty != 4'h3 && ty != 4'hB)) begin
            e_flt = 2'd1; e_reqs = 3;                             // R4 R6
        end else if (!hi[15]) begin
            e_flt = 2'd2; e_reqs = 3;                             // R5
        end else begin
            e_flt = 2'd0; e_err = 16'h0; e_reqs = 3;              // R7
        end
        chk(fault_o == e_flt, "R2/R3/R4/R5/R6/R8 fault class", 32'(fault_o), 32'(e_flt));
        chk(err_code_o == e_err, "R2 error code", 32'(err_code_o), 32'(e_err));
        chk(ok_o == (e_flt == 2'd0), "R7 ok flag", 32'(ok_o), 32'(e_flt == 2'd0));
        chk(n_req - base == e_reqs, "R8 read count", 32'(n_req - base), 32'(e_reqs));
        if (e_reqs >= 1)
            chk(req_log[base[9:0]] == TSS_BASE, "R1 link address",
                32'(req_log[base[9:0]]), 32'(TSS_BASE));
        if (e_reqs == 3) begin
            chk(req_log[(base+1) & 1023] == GDT_BASE + 16'({sel[15:3], 3'b000}),
                "R10 low word address", 32'(req_log[(base+1) & 1023]),
                32'(GDT_BASE + 16'({sel[15:3], 3'b000})));
            chk(req_log[(base+2) & 1023] == GDT_BASE + 16'({sel[15:3], 3'b100}),
                "R10 high word address", 32'(req_log[(base+2) & 1023]),
                32'(GDT_BASE + 16'({sel[15:3], 3'b100})));
        end
        if (e_flt == 2'd0) begin
            chk(link_sel_o == sel, "R7 link selector", 32'(link_sel_o), 32'(sel));
            chk(desc_lo_o == lo, "R7 descriptor low", desc_lo_o, lo);
            chk(desc_hi_o == hi, "R7 descriptor high", desc_hi_o, hi);
        end
        @(negedge clk);
        chk(!done_o, "R9 single-cycle pulse", 32'(done_o), 32'd0);
        @(negedge clk);
        @(negedge clk);
        chk(fault_o == e_flt && err_code_o == e_err, "R9 result held",
            {14'd0, fault_o, err_code_o}, {14'd0, e_flt, e_err});
    endtask

    function automatic logic [31:0] mk_hi(input bit p, input bit s, input logic [3:0] t);
        return {16'h00CF, p, 2'b00, s, t, 8'h12};
    endfunction

    initial begin
        #(20 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        n_chk = 0;
        n_fail = 0;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        chk(!done_o && !mem_req_o && fault_o == 2'd0, "R9 reset state",
            {30'd0, done_o, mem_req_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R5 R6 R7: sweep type, S and present over a valid global selector
        for (int t = 0; t < 16; t++)
            for (int s = 0; s < 2; s++)
                for (int p = 0; p < 2; p++)
                    run(16'h002B, 32'h1234_0000 + 32'(t), mk_hi(p[0], s[0], 4'(t)),
                        16'h00FF, 1'b0);

        // R2: local-table selectors of every RPL, good descriptor behind them
        for (int rpl = 0; rpl < 4; rpl++)
            run(16'h0034 | 16'(rpl), 32'h0, mk_hi(1'b1, 1'b0, 4'hB), 16'h00FF, 1'b0);

        // R3: limit boundary
        run(16'h0048, 32'hAAAA_5555, mk_hi(1'b1, 1'b0, 4'h3), 16'd79, 1'b0);
        run(16'h0048, 32'hAAAA_5555, mk_hi(1'b1, 1'b0, 4'h3), 16'd78, 1'b0);
        run(16'h0003, 32'h0000_FFFF, mk_hi(1'b1, 1'b0, 4'hB), 16'd7, 1'b0);
        run(16'h0003, 32'h0000_FFFF, mk_hi(1'b1, 1'b0, 4'hB), 16'd6, 1'b0);
        for (int ix = 1; ix < 32; ix += 5) begin
            run(16'({ix[12:0], 3'b001}), 32'(ix), mk_hi(1'b1, 1'b0, 4'hB),
                16'(ix * 8 + 7), 1'b0);
            run(16'({ix[12:0], 3'b001}), 32'(ix), mk_hi(1'b1, 1'b0, 4'hB),
                16'(ix * 8 + 6), 1'b0);
        end

        // R6: several failures at once, first one wins
        run(16'h0FFE, 32'h0, mk_hi(1'b0, 1'b1, 4'h0), 16'h000F, 1'b0);
        run(16'h0052, 32'h0, mk_hi(1'b0, 1'b1, 4'h2), 16'h0000, 1'b0);
        run(16'h0052, 32'h0, mk_hi(1'b0, 1'b0, 4'h9), 16'h00FF, 1'b0);

        // R8: virtual-8086 flag set
        run(16'h002B, 32'h1, mk_hi(1'b1, 1'b0, 4'hB), 16'h00FF, 1'b1);
        run(16'h0034, 32'h1, mk_hi(1'b0, 1'b1, 4'h0), 16'h0000, 1'b1);
        // back to a clean success after the internal error
        run(16'h0050, 32'hCAFE_F00D, mk_hi(1'b1, 1'b0, 4'h3), 16'h00FF, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule